// File: doc/BRIEF.md
# MSI-X Capability Register Block

This block holds the twelve-byte MSI-X capability structure that a device exposes in configuration space. It also works out where the vector table and the pending-bit array sit inside one memory BAR. The entry count, the BAR number and the BAR's original size are elaboration-time parameters. From them the block derives the enlarged BAR size, the table and pending-array locator dwords, and an error flag for an impossible setup.

Software reaches the structure through a dword-addressed configuration port with byte enables. Reads return the current contents in the cycle of the request. Only two control bits can be written: the enable bit and the function-mask bit.

A write that covers the upper control byte, and that leaves enable set, produces two registered one-cycle pulses:
- one pulse tells the device to drop its legacy interrupt;
- a second pulse, produced only when the function mask ends up clear, asks the delivery logic to sweep every vector for pending messages.

Top module: `msix_cap_block`

## Requirements
- R1: A read of dword 0 returns the capability ID 0x11 in bits 7:0 and zero in bits 15:8. A read of dword 3 returns zero.
- R2: Bits 26:16 of dword 0 (control bits 10:0) hold the entry count minus one. Bits 29:27 read as zero.
- R3: Only bit 31 (enable) and bit 30 (function mask) of dword 0 can be written. A write changes them only when byte enable 3 is set on dword 0. Every other bit, and all of dwords 1 to 3, ignore writes.
- R4: The table base and the enlarged BAR size follow the original BAR size:
  - original size 0: base 0, new size 4096;
  - original size 1 to 4095: base 4096, new size 8192;
  - otherwise: base equals the original size, and the new size is twice the original size.
- R5: Dword 1 equals the table base ORed with the BAR number in bits 2:0. Dword 2 equals (table base + 2048) ORed with the same BAR number.
- R6: The error output is high exactly when the entry count is 0, the entry count is above 2048, or the original BAR size is above 0x80000000.
- R7: A write covering byte 3 of dword 0 that leaves enable set raises the legacy-clear output for exactly the one cycle after the write edge.
- R8: Such a write that also leaves the function mask clear raises the sweep output in that same cycle. The sweep output is never high without the legacy-clear output.
- R9: A write that does not cover byte 3 of dword 0, or that leaves enable clear, raises neither pulse.
- R10: Reset clears enable, the function mask and both pulses.
- R11: Reads have no side effects, and the read data is zero when no read is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_rd | input | 1 | Read request (data valid in the same cycle) |
| cfg_wr | input | 1 | Write request |
| cfg_dw | input | 2 | Dword index inside the capability |
| cfg_be | input | 4 | Byte enables of the write |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data, zero when cfg_rd is low |
| bar_size_out | output | 33 | Enlarged BAR size in bytes |
| cfg_error | output | 1 | Parameter set is invalid |
| vec_enable | output | 1 | Enable bit level |
| func_masked | output | 1 | Function-mask bit level |
| legacy_clr | output | 1 | One-cycle pulse: drop the legacy interrupt |
| sweep_req | output | 1 | One-cycle pulse: re-check pending vectors |

## Verification
The legacy-clear pulse and the sweep pulse can fall in the same cycle, and the stimulus provokes this with writes that set enable and clear the function mask. Random writes are mixed in, with random dword indices, byte enables and data. Each one is judged against a bench model that tracks both control bits and predicts both pulses from the values the bits hold after the write.

A read also overlaps the pulse cycle, so the bench checks that reading back the control word in that cycle shows the new bits and leaves no extra pulse behind.

// File: rtl/msix_cap_pkg.sv
// Package: shared constants and types for the MSI-X capability block.
// Assumes a 4 KiB region for table plus pending array, pending array in
// the upper half of that region.
package msix_cap_pkg;
    localparam logic [7:0]  CAP_ID       = 8'h11;
    localparam int unsigned REGION_BYTES = 4096;
    localparam int unsigned PEND_OFFSET  = REGION_BYTES / 2;
    localparam int unsigned QSIZE_W      = 11;
    localparam int unsigned MAX_VECTORS  = 1 << QSIZE_W;
    localparam logic [32:0] MAX_BAR_IN   = 33'h0_8000_0000;
    // Positions inside dword 0 of the two writable bits
    localparam int unsigned EN_BIT       = 31;
    localparam int unsigned FMASK_BIT    = 30;
    localparam int unsigned CTRL_BYTE    = 3;

    typedef struct packed {
        logic enable;
        logic fmask;
    } ctrl_t;
endpackage

// File: rtl/msix_bar_layout.sv
// Module: msix_bar_layout
// Derives, from static parameters only, the enlarged BAR size, the table
// and pending locator dwords and the configuration error flag.
// Assumes BAR_IN is zero or a power of two; picks one of three placements.
module msix_bar_layout
    import msix_cap_pkg::*;
#(
    parameter int unsigned NUM_VECTORS = 8,
    parameter int unsigned BAR_INDEX   = 0,
    parameter logic [32:0] BAR_IN      = 33'h2000
) (
    output logic [32:0] bar_size,
    output logic [31:0] table_dw,
    output logic [31:0] pend_dw,
    output logic        bad_cfg
);
    localparam logic [2:0] BIR = BAR_INDEX[2:0];
    localparam bit COUNT_BAD = (NUM_VECTORS < 1) || (NUM_VECTORS > MAX_VECTORS);
    localparam bit BAR_BAD   = (BAR_IN > MAX_BAR_IN);

    logic [32:0] base;

    // Placement variant chosen by the original BAR size
    generate
        if (BAR_IN == 33'd0) begin : g_empty_bar
            assign base     = 33'd0;
            assign bar_size = 33'(REGION_BYTES);
        end else if (BAR_IN < 33'(REGION_BYTES)) begin : g_small_bar
            assign base     = 33'(REGION_BYTES);
            assign bar_size = 33'(2 * REGION_BYTES);
        end else begin : g_large_bar
            assign base     = BAR_IN;
            assign bar_size = {BAR_IN[31:0], 1'b0};
        end
    endgenerate

    // Locator dwords: base ORed with the BAR number in the low bits
    always_comb begin
        table_dw = base[31:0] | {29'd0, BIR};
        pend_dw  = (base[31:0] + 32'(PEND_OFFSET)) | {29'd0, BIR};
    end

    assign bad_cfg = COUNT_BAD || BAR_BAD;
endmodule

// File: rtl/msix_ctrl_reg.sv
// Module: msix_ctrl_reg
// Holds the enable and function-mask bits and produces the registered
// legacy-clear and sweep pulses. Side effects use post-write bit values.
// Assumes one write per cycle; write to dword 0 byte 3 is the trigger.
module msix_ctrl_reg
    import msix_cap_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr,
    input  logic [1:0]  dw,
    input  logic [3:0]  be,
    input  logic [31:0] wdata,
    output ctrl_t       ctrl,
    output logic        legacy_clr,
    output logic        sweep_req
);
    logic  hit;
    ctrl_t nxt;

    // Decode a write covering the control byte and form next bit values
    always_comb begin
        hit = wr && (dw == 2'd0) && be[CTRL_BYTE];
        nxt = ctrl;
        if (hit) begin
            nxt.enable = wdata[EN_BIT];
            nxt.fmask  = wdata[FMASK_BIT];
        end
    end

    // Control bits and one-cycle side-effect pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl       <= '0;
            legacy_clr <= 1'b0;
            sweep_req  <= 1'b0;
        end else begin
            ctrl       <= nxt;
            legacy_clr <= hit && nxt.enable;
            sweep_req  <= hit && nxt.enable && !nxt.fmask;
        end
    end
endmodule

// File: rtl/msix_read_mux.sv
// Module: msix_read_mux
// Assembles the capability dwords and returns the addressed one in the
// same cycle. Pure combinational; reads never alter state.
module msix_read_mux
    import msix_cap_pkg::*;
#(
    parameter int unsigned NUM_VECTORS = 8
) (
    input  logic        rd,
    input  logic [1:0]  dw,
    input  ctrl_t       ctrl,
    input  logic [31:0] table_dw,
    input  logic [31:0] pend_dw,
    output logic [31:0] rdata
);
    localparam logic [QSIZE_W-1:0] QSIZE = QSIZE_W'(NUM_VECTORS - 1);

    logic [15:0] ctrl_word;

    // Control word: enable, mask, reserved zeros, entry count minus one
    assign ctrl_word = {ctrl.enable, ctrl.fmask, 3'b000, QSIZE};

    // Select addressed dword, zero when no read is requested
    always_comb begin
        rdata = '0;
        if (rd) begin
            unique case (dw)
                2'd0:    rdata = {ctrl_word, 8'h00, CAP_ID};
                2'd1:    rdata = table_dw;
                2'd2:    rdata = pend_dw;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/msix_cap_block.sv
// Module: msix_cap_block (top)
// MSI-X capability structure with BAR placement of table and pending
// array. Capability linking and BAR decode are handled elsewhere.
module msix_cap_block
    import msix_cap_pkg::*;
#(
    parameter int unsigned NUM_VECTORS = 8,
    parameter int unsigned BAR_INDEX   = 2,
    parameter logic [32:0] BAR_IN      = 33'h2000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_rd,
    input  logic        cfg_wr,
    input  logic [1:0]  cfg_dw,
    input  logic [3:0]  cfg_be,
    input  logic [31:0] cfg_wdata,
    output logic [31:0] cfg_rdata,
    output logic [32:0] bar_size_out,
    output logic        cfg_error,
    output logic        vec_enable,
    output logic        func_masked,
    output logic        legacy_clr,
    output logic        sweep_req
);
    ctrl_t       ctrl;
    logic [31:0] table_dw;
    logic [31:0] pend_dw;

    msix_bar_layout #(
        .NUM_VECTORS(NUM_VECTORS), .BAR_INDEX(BAR_INDEX), .BAR_IN(BAR_IN)
    ) u_layout (
        .bar_size(bar_size_out), .table_dw(table_dw),
        .pend_dw(pend_dw), .bad_cfg(cfg_error)
    );

    msix_ctrl_reg u_ctrl (
        .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .dw(cfg_dw), .be(cfg_be),
        .wdata(cfg_wdata), .ctrl(ctrl),
        .legacy_clr(legacy_clr), .sweep_req(sweep_req)
    );

    msix_read_mux #(.NUM_VECTORS(NUM_VECTORS)) u_rmux (
        .rd(cfg_rd), .dw(cfg_dw), .ctrl(ctrl),
        .table_dw(table_dw), .pend_dw(pend_dw), .rdata(cfg_rdata)
    );

    assign vec_enable  = ctrl.enable;
    assign func_masked = ctrl.fmask;
endmodule

// File: rtl/msix_cap_chk.sv
// Module: msix_cap_chk
// Port-level temporal checks for msix_cap_block, attached by bind.
module msix_cap_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cfg_rd,
    input logic        cfg_wr,
    input logic [1:0]  cfg_dw,
    input logic [3:0]  cfg_be,
    input logic [31:0] cfg_wdata,
    input logic [31:0] cfg_rdata,
    input logic        vec_enable,
    input logic        func_masked,
    input logic        legacy_clr,
    input logic        sweep_req
);
    logic cover_ctl;
    assign cover_ctl = cfg_wr && (cfg_dw == 2'd0) && cfg_be[3];

    // R3
    ctl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cover_ctl |=> ($stable(vec_enable) && $stable(func_masked)));

    // R7
    legacy_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cover_ctl && cfg_wdata[31]) |=> legacy_clr);

    // R8
    sweep_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_req |-> legacy_clr);

    // R8
    sweep_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cover_ctl && cfg_wdata[31] && !cfg_wdata[30]) |=> sweep_req);

    // R9
    quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(cover_ctl && cfg_wdata[31]) |=> (!legacy_clr && !sweep_req));

    // R10
    reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!vec_enable && !func_masked && !legacy_clr));

    // R11
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_rd |-> (cfg_rdata == 32'd0));
endmodule

bind msix_cap_block msix_cap_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
    .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .vec_enable(vec_enable),
    .func_masked(func_masked), .legacy_clr(legacy_clr),
    .sweep_req(sweep_req)
);

// File: tb/sim_msix_cap_block.sv
// Bench: seeded random writes plus directed corners for msix_cap_block.
module sim_msix_cap_block;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_rd = 1'b0, cfg_wr = 1'b0;
    logic [1:0]  cfg_dw = '0;
    logic [3:0]  cfg_be = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] rd0, rd1, rd2, rd3;
    logic [32:0] bs0, bs1, bs2, bs3;
    logic        er0, er1, er2, er3;
    logic        en0, fm0, lc0, sw0;
    logic        en1, fm1, lc1, sw1, en2, fm2, lc2, sw2, en3, fm3, lc3, sw3;

    int n_tests = 0, n_fail = 0;
    bit m_en = 0, m_fm = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    msix_cap_block u0 (.clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd0),
        .bar_size_out(bs0), .cfg_error(er0), .vec_enable(en0), .func_masked(fm0),
        .legacy_clr(lc0), .sweep_req(sw0));
    msix_cap_block #(.NUM_VECTORS(1), .BAR_INDEX(5), .BAR_IN(33'd0)) u1 (
        .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd1),
        .bar_size_out(bs1), .cfg_error(er1), .vec_enable(en1), .func_masked(fm1),
        .legacy_clr(lc1), .sweep_req(sw1));
    msix_cap_block #(.NUM_VECTORS(2048), .BAR_INDEX(1), .BAR_IN(33'd100)) u2 (
        .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd2),
        .bar_size_out(bs2), .cfg_error(er2), .vec_enable(en2), .func_masked(fm2),
        .legacy_clr(lc2), .sweep_req(sw2));
    msix_cap_block #(.NUM_VECTORS(2049), .BAR_INDEX(0), .BAR_IN(33'h0_8000_0001)) u3 (
        .clk(clk), .rst_n(rst_n), .cfg_rd(cfg_rd), .cfg_wr(cfg_wr),
        .cfg_dw(cfg_dw), .cfg_be(cfg_be), .cfg_wdata(cfg_wdata), .cfg_rdata(rd3),
        .bar_size_out(bs3), .cfg_error(er3), .vec_enable(en3), .func_masked(fm3),
        .legacy_clr(lc3), .sweep_req(sw3));

    // Expected values from the requirements
    function automatic logic [32:0] exp_base(input logic [32:0] bar);
        if (bar == 0) return 33'd0;
        if (bar < 33'd4096) return 33'd4096;
        return bar;
    endfunction
    function automatic logic [32:0] exp_size(input logic [32:0] bar);
        if (bar == 0) return 33'd4096;
        if (bar < 33'd4096) return 33'd8192;
        return bar << 1;
    endfunction
    function automatic logic [31:0] exp_dw0(input bit e, input bit f, input int nv);
        logic [10:0] q = 11'(nv - 1);
        return {e, f, 3'b000, q, 8'h00, 8'h11};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic read_dw(input logic [1:0] d, output logic [31:0] v);
        cfg_dw = d; cfg_rd = 1'b1;
        #1 v = rd0;
        cfg_rd = 1'b0;
    endtask

    // Write, then sample pulses in the cycle after the edge and check model
    task automatic write_chk(input logic [1:0] d, input logic [3:0] b, input logic [31:0] w);
        bit hit, ex_l, ex_s;
        logic [31:0] v;
        @(negedge clk);
        cfg_wr = 1'b1; cfg_dw = d; cfg_be = b; cfg_wdata = w;
        @(negedge clk);
        cfg_wr = 1'b0;
        hit = (d == 2'd0) && b[3];
        if (hit) begin m_en = w[31]; m_fm = w[30]; end
        ex_l = hit && m_en;
        ex_s = ex_l && !m_fm;
        check("R7 legacy_clr", 64'(lc0), 64'(ex_l));
        check("R8 sweep_req", 64'(sw0), 64'(ex_s));
        if (!ex_l) check("R9 no pulse", 64'({lc0, sw0}), 64'd0);
        read_dw(2'd0, v);
        check("R3 dword0 after write", 64'(v), 64'(exp_dw0(m_en, m_fm, 8)));
    endtask

    initial begin
        logic [31:0] v;
        #(CLK_PERIOD * 20000);
        n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] v;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 reset bits", 64'({en0, fm0, lc0, sw0}), 64'd0);
        // R1 / R2 read contents
        read_dw(2'd0, v);
        check("R1 R2 dword0", 64'(v), 64'(exp_dw0(0, 0, 8)));
        read_dw(2'd3, v);
        check("R1 dword3", 64'(v), 64'd0);
        // R11 idle read data zero
        check("R11 idle rdata", 64'(rd0), 64'd0);
        // R4 / R5 placements for the four instances
        read_dw(2'd1, v);
        check("R5 table u0", 64'(v), 64'(32'h2000 | 32'd2));
        read_dw(2'd2, v);
        check("R5 pending u0", 64'(v), 64'(32'h2800 | 32'd2));
        check("R4 size u0", 64'(bs0), 64'(exp_size(33'h2000)));
        check("R4 size u1", 64'(bs1), 64'(exp_size(33'd0)));
        check("R4 size u2", 64'(bs2), 64'(exp_size(33'd100)));
        check("R4 size u3", 64'(bs3), 64'(exp_size(33'h0_8000_0001)));
        cfg_rd = 1'b1; cfg_dw = 2'd1; #1;
        check("R5 table u1", 64'(rd1), 64'(exp_base(33'd0)) | 64'd5);
        check("R5 table u2", 64'(rd2), 64'(exp_base(33'd100)) | 64'd1);
        cfg_dw = 2'd2; #1;
        check("R5 pending u1", 64'(rd1), 64'(32'd2048 | 32'd5));
        cfg_dw = 2'd0; #1;
        check("R2 count u1", 64'(rd1), 64'(exp_dw0(0, 0, 1)));
        check("R2 count u2", 64'(rd2), 64'(exp_dw0(0, 0, 2048)));
        cfg_rd = 1'b0;
        // R6 error flag
        check("R6 error ok", 64'({er0, er1, er2}), 64'd0);
        check("R6 error bad", 64'(er3), 64'd1);
        // Directed: enable + unmask -> both pulses (R7, R8)
        write_chk(2'd0, 4'b1000, 32'h8000_0000);
        // Enable + mask -> legacy only
        write_chk(2'd0, 4'b1000, 32'hC000_0000);
        // Not covering byte 3 -> nothing (R9, R3)
        write_chk(2'd0, 4'b0111, 32'h0000_0000);
        // Read-only dwords ignore writes (R3)
        write_chk(2'd1, 4'b1111, 32'hFFFF_FFFF);
        read_dw(2'd1, v);
        check("R3 table read-only", 64'(v), 64'(32'h2002));
        // Disable -> nothing (R9)
        write_chk(2'd0, 4'b1111, 32'h7FFF_FFFF);
        // Random writes
        for (int i = 0; i < 80; i++) begin
            logic [1:0] d = 2'($urandom_range(0, 3));
            logic [3:0] b = 4'($urandom);
            logic [31:0] w = $urandom;
            if (i % 4 == 0) d = 2'd0;
            write_chk(d, b, w);
        end
        // Reset mid-run clears bits (R10)
        write_chk(2'd0, 4'b1000, 32'hC000_0000);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        m_en = 0; m_fm = 0;
        check("R10 reset again", 64'({en0, fm0, lc0, sw0}), 64'd0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule